// File: doc/BRIEF.md
# Priority-Nested Vectored Interrupt Controller

This block arbitrates among a parameterised set of interrupt nodes and hands the CPU one request at a time, together with the index of the winning node. Each node holds its own configuration byte. That byte contains a pending flag, an enable, a 4-bit priority level and an edge-mode field. Peripheral logic raises a node with a one-cycle event pulse. The lowest-numbered nodes can also be driven by asynchronous external pins, which go through a two-flop synchronizer and a programmable edge detector. Software can read and write every configuration byte. Writing the pending bit raises the node directly, and this works on any node, whether or not anything drives its event input.

The controller holds the priority of the service that is running. It requests the CPU only when the best enabled pending node has a strictly higher level. Level 0 never requests, so it acts as a per-node disable. When the CPU acknowledges, the controller clears the winner's pending flag, saves the running level on a nesting stack and adopts the winner's level. A return-from-interrupt pulse restores the saved level. Because every nested service must carry a strictly higher level, the stack never needs more than fifteen entries.

Top module: `pnvic_top`

## Requirements
- R1: After reset every configuration byte reads 0, `irq_req` is low and `cur_level` is 0.
- R2: A configuration byte read back on `reg_rdata` returns exactly what was written. Its layout is: bit 7 pending flag, bit 6 enable, bits 5:4 edge mode, bits 3:0 level.
- R3: A node whose level is 0 never causes `irq_req`, even when it is enabled and pending.
- R4: `irq_req` is high exactly when some node is pending, enabled and has a level above `cur_level`, and `irq_vec` then names the winning node. Writing bit 7 = 1 makes a node pending, and bit 6 = 0 blocks it.
- R5: Among pending enabled nodes that share the highest level, the node with the lowest index wins.
- R6: An acknowledge while `irq_req` is high clears the winner's pending flag and sets `cur_level` to the winner's level on the next cycle.
- R7: While a service runs, a pending node of equal or lower level does not request. A strictly higher one does.
- R8: Each `irq_ret` pulse restores the level that was running before the most recent accepted acknowledge. With nothing saved, it leaves level 0. If `irq_ret` and `irq_ack` arrive in the same cycle, the acknowledge is ignored.
- R9: External pin p drives node p. Edge mode 01 sets the flag on a rising edge, 10 on a falling edge, 11 on either edge, and 00 never. The flag becomes visible on the third rising clock edge after the pin changes.
- R10: A one-cycle pulse on `node_evt[i]` sets the pending flag of node i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_evt | input | NODES | Per-node peripheral event pulses |
| ext_pin | input | EXT_PINS | Asynchronous external interrupt pins, pin p drives node p |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | IDX_W | Node index for read and write |
| reg_wdata | input | 8 | Configuration byte to write |
| reg_rdata | output | 8 | Configuration byte of the addressed node |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | IDX_W | Index of the winning node |
| irq_ack | input | 1 | CPU accepts the current request |
| irq_ret | input | 1 | CPU returns from the running service |
| cur_level | output | 4 | Priority level of the running service |

## Verification
Some properties are checked on every cycle by assertions inside the RTL:
- a request always names a node that is enabled and pending;
- an acknowledge both clears that node's flag and adopts its level;
- the running level rises only through an acknowledge;
- a return never raises the level;
- the nesting stack never overflows.

Other behaviour only the bench scenarios can show, because it depends on ordered stimulus over many cycles:
- the lowest-index tie-break;
- the rejection of an equal-level request during a service;
- the pre-emption and unwinding of a two-deep nest;
- the exact three-edge synchronizer latency in each of the four edge modes.

// File: rtl/pnvic_pkg.sv
package pnvic_pkg;

    localparam int LVL_W = 4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic             pend;
        logic             en;
        edge_mode_e       mode;
        logic [LVL_W-1:0] lvl;
    } node_cfg_t;

endpackage

// File: rtl/pnvic_edge_sync.sv
module pnvic_edge_sync
    import pnvic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       hit
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        rise      = st_q.s2 & ~st_q.prev;
        fall      = ~st_q.s2 & st_q.prev;
        unique case (mode)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !hit); // R9

endmodule

// File: rtl/pnvic_arbiter.sv
module pnvic_arbiter
    import pnvic_pkg::*;
#(
    parameter int NODES = 8,
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  node_cfg_t [NODES-1:0] cfg,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic [LVL_W-1:0]      win_lvl
);

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NODES; i++) begin
            if (cfg[i].pend && cfg[i].en && cfg[i].lvl > win_lvl) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = cfg[i].lvl;
            end
        end
    end

endmodule

// File: rtl/pnvic_stack.sv
module pnvic_stack #(
    parameter int DEPTH = 15,
    parameter int W     = 4,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           ptr;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        top  = (st_q.ptr == '0) ? '0 : st_q.mem[st_q.ptr - 1'b1];
        if (pop) begin
            if (st_q.ptr != '0) st_d.ptr = st_q.ptr - 1'b1;
        end else if (push && st_q.ptr != PW'(DEPTH)) begin
            st_d.mem[st_q.ptr] = din;
            st_d.ptr           = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.ptr != PW'(DEPTH))); // R6

endmodule

// File: rtl/pnvic_top.sv
module pnvic_top
    import pnvic_pkg::*;
#(
    parameter int NODES    = 8,
    parameter int EXT_PINS = 2,
    localparam int IDX_W   = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int NEST    = (1 << LVL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] node_evt,
    input  logic [EXT_PINS-1:0] ext_pin,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq_req,
    output logic [IDX_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic [LVL_W-1:0] cur_level
);

    typedef struct packed {
        node_cfg_t [NODES-1:0] cfg;
        logic [LVL_W-1:0]      cur;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NODES-1:0] ext_hit;
    logic [NODES-1:0] hw_set;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W-1:0] saved_lvl;
    logic             take;

    for (genvar g = 0; g < NODES; g++) begin : g_node
        if (g < EXT_PINS) begin : g_ext
            pnvic_edge_sync u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ext_pin[g]),
                .mode (st_q.cfg[g].mode),
                .hit  (ext_hit[g])
            );
        end else begin : g_int
            assign ext_hit[g] = 1'b0;
        end
    end

    assign hw_set = node_evt | ext_hit;

    pnvic_arbiter #(.NODES(NODES)) u_arb (
        .cfg      (st_q.cfg),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    pnvic_stack #(.DEPTH(NEST), .W(LVL_W)) u_stk (
        .clk  (clk),
        .rst_n(rst_n),
        .push (take),
        .pop  (irq_ret),
        .din  (st_q.cur),
        .top  (saved_lvl)
    );

    assign irq_req   = win_valid && (win_lvl > st_q.cur);
    assign irq_vec   = win_idx;
    assign cur_level = st_q.cur;
    assign take      = irq_ack && irq_req && !irq_ret;
    assign reg_rdata = (int'(reg_addr) < NODES) ? st_q.cfg[reg_addr] : 8'h00;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NODES; i++) begin
            if (reg_we && int'(reg_addr) == i) st_d.cfg[i] = reg_wdata;
            if (take && int'(win_idx) == i)    st_d.cfg[i].pend = 1'b0;
            if (hw_set[i])                     st_d.cfg[i].pend = 1'b1;
        end
        if (irq_ret)   st_d.cur = saved_lvl;
        else if (take) st_d.cur = win_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_REQ_NODE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (st_q.cfg[irq_vec].pend && st_q.cfg[irq_vec].en)); // R4
    AST_ACK_ADOPTS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_level == $past(win_lvl))); // R6
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !hw_set[win_idx]) |=> !st_q.cfg[$past(win_idx)].pend); // R6
    AST_RISE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level > $past(cur_level)) |-> $past(take)); // R7
    AST_RET_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ret |=> (cur_level <= $past(cur_level))); // R8

endmodule

// File: tb/pnvic_top_bench.sv
module pnvic_top_bench;

    localparam int NODES = 8;
    localparam int EXT   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NODES-1:0] node_evt = '0;
    logic [EXT-1:0]   ext_pin = '0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             irq_req;
    logic [2:0]       irq_vec;
    logic             irq_ack = 1'b0;
    logic             irq_ret = 1'b0;
    logic [3:0]       cur_level;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        int    kind; // 0 req, 1 vec, 2 level, 3 rdata
        int    exp;
        string tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    pnvic_top #(.NODES(NODES), .EXT_PINS(EXT)) u_pnvic_top (
        .clk(clk), .rst_n(rst_n), .node_evt(node_evt), .ext_pin(ext_pin),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .cur_level(cur_level)
    );

    // Monitor: compares queued expectations against outputs settled before this edge
    always @(posedge clk) begin
        cycles++;
        while (sb.size() > 0) begin
            item_t it;
            int    act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = int'(irq_req);
                1:       act = int'(irq_vec);
                2:       act = int'(cur_level);
                default: act = int'(reg_rdata);
            endcase
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
            end
        end
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic exp_rd(input int a, input int d, input string tag);
        reg_addr = 3'(a);
        sb.push_back('{3, d, tag});
        tick();
    endtask

    task automatic exp_out(input int rq, input int vec, input int lvl, input string tag);
        sb.push_back('{0, rq, tag});
        if (rq != 0) sb.push_back('{1, vec, tag});
        sb.push_back('{2, lvl, tag});
        tick();
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    endtask

    task automatic pin_step(input logic v, input int exp, input string tag);
        ext_pin[0] = v;
        tick(2);
        exp_rd(0, exp & 8'h7f, {tag, " latency"});
        exp_rd(0, exp, tag);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        exp_out(0, 0, 0, "R1 reset outputs");
        exp_rd(3, 8'h00, "R1 reset config");
        // R2 byte layout round trip
        wr(5, 8'h7A);
        exp_rd(5, 8'h7A, "R2 readback");
        // R3 level zero is silent
        wr(5, 8'hC0);
        exp_out(0, 0, 0, "R3 level zero");
        // R4 enable gates, software pend raises
        wr(5, 8'h00);
        wr(4, 8'h89);
        exp_out(0, 0, 0, "R4 disabled node");
        wr(4, 8'hC9);
        exp_out(1, 4, 0, "R4 software set");
        wr(4, 8'h00);
        // R5 tie-break
        wr(6, 8'hC7);
        wr(3, 8'hC7);
        wr(2, 8'hC5);
        exp_out(1, 3, 0, "R5 lowest index wins");
        // R6 acknowledge
        ack();
        exp_rd(3, 8'h47, "R6 flag cleared");
        // R7 equal level rejected
        exp_out(0, 0, 7, "R7 equal level blocked");
        wr(7, 8'hCB);
        exp_out(1, 7, 7, "R7 higher pre-empts");
        ack();
        exp_out(0, 0, 11, "R6 nested level");
        // R8 unwinding
        ret();
        exp_out(0, 0, 7, "R8 first return");
        ret();
        exp_out(1, 6, 0, "R8 second return");
        ret();
        exp_out(1, 6, 0, "R8 empty return");
        wr(6, 8'h00);
        wr(2, 8'h00);
        // R10 peripheral pulse
        wr(5, 8'h45);
        node_evt[5] = 1'b1; tick(); node_evt[5] = 1'b0;
        exp_rd(5, 8'hC5, "R10 pulse sets flag");
        exp_out(1, 5, 0, "R10 pulse request");
        ack();
        ret();
        wr(5, 8'h00);
        // R9 edge modes on pin 0 / node 0
        wr(0, 8'h10);
        pin_step(1'b1, 8'h90, "R9 rise mode rising");
        wr(0, 8'h10);
        pin_step(1'b0, 8'h10, "R9 rise mode falling");
        wr(0, 8'h20);
        pin_step(1'b1, 8'h20, "R9 fall mode rising");
        pin_step(1'b0, 8'hA0, "R9 fall mode falling");
        wr(0, 8'h30);
        pin_step(1'b1, 8'hB0, "R9 both mode rising");
        wr(0, 8'h30);
        pin_step(1'b0, 8'hB0, "R9 both mode falling");
        wr(0, 8'h00);
        pin_step(1'b1, 8'h00, "R9 off mode rising");
        pin_step(1'b0, 8'h00, "R9 off mode falling");
        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule